// File: doc/BRIEF.md
# Row and Column Matrix Store

This block holds a square matrix of words (16 by 16 elements of 32 bits by default) and hands back an entire row or an entire column in one read. Elements are loaded one at a time: a write names the row, the column and the data. A read names an orientation and an index. One clock later the 16 selected elements appear side by side on a 512-bit bus, together with a one-cycle valid flag.

Inside, the matrix is kept twice. One copy is split into banks by column, so that the 16 banks read at the same address give a row. The other copy is split into banks by row, so that the same read gives a column. Every write goes into both copies. No bank ever has to serve more than one address in a cycle, so single-port-read storage is enough. Typical users are transform and matrix engines that sweep first along rows and then along columns.

Top module: `matmem_rowcol`

## Requirements
- R1: A write with `wrEn` high stores `wrData` at element (`wrRow`, `wrCol`). After that, both a row read of `wrRow` and a column read of `wrCol` return the new value.
- R2: A read with `rdEn` high and `rdSelCol` = 0 returns row `rdIdx`. Element k of the row, with k being the column index, sits in `rdData[32k+31:32k]`.
- R3: A read with `rdEn` high and `rdSelCol` = 1 returns column `rdIdx`. Element k of the column, with k being the row index, sits in `rdData[32k+31:32k]`.
- R4: `rdData` takes the result on the clock edge that samples `rdEn`. `rdValid` is high in exactly the cycle after each cycle in which `rdEn` was high, and low otherwise.
- R5: If a write and a read that covers the same element happen in the same cycle, the read returns the value held before the write. The next read returns the new value.
- R6: A synchronous reset (`rst` high at a clock edge) clears `rdData` to zero and `rdValid` to 0. The stored matrix is left unchanged.
- R7: While `rdEn` is low, `rdData` keeps its last value.
- R8: Repeated writes to the same element leave only the last written value visible, in both orientations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the read output only |
| wrEn | input | 1 | Write strobe for one element |
| wrRow | input | 4 | Row index of the element written |
| wrCol | input | 4 | Column index of the element written |
| wrData | input | 32 | Element value to store |
| rdEn | input | 1 | Read request |
| rdSelCol | input | 1 | Orientation: 0 returns a row, 1 returns a column |
| rdIdx | input | 4 | Row or column number to return |
| rdData | output | 512 | Sixteen elements, element k in bits [32k+31:32k] |
| rdValid | output | 1 | High for the one cycle in which a read result is fresh |

## Verification
A write takes effect at the edge that samples it, so a read of the same element issued in the following cycle already sees it. A read result and its valid flag are due one edge after the request, so the bench drives each request on a falling edge and checks `rdData` and `rdValid` on the next falling edge, after exactly one rising edge has passed. A write and a read of the same element on the same falling edge test read-before-write: the old value is expected on the next falling edge, and the new value one read later. Hold and reset results are checked several falling edges after the last request, to make sure nothing moves during idle cycles.

// File: rtl/matmem_pkg.sv
package matmem_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic wrGo;       // store one element into both copies
    logic rdGo;       // load the output register
    logic rdColMode;  // 1: take the column copy, 0: take the row copy
    logic clrOut;     // clear the output register
  } mm_strobe_t;

endpackage

// File: rtl/matmem_bank.sv
// One bank: DEPTH words with a synchronous write and an asynchronous read.
module matmem_bank #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wAddr,
  input  logic [WIDTH-1:0] wData,
  input  logic [AW-1:0]    rAddr,
  output logic [WIDTH-1:0] rData
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
  end

  // Combinational read shows the contents held before this edge's write
  always_comb rData = mem[rAddr];

endmodule

// File: rtl/matmem_ctrl.sv
// Control: turns the request ports into datapath strobes and tracks valid.
module matmem_ctrl
  import matmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       rdSelCol,
  output mm_strobe_t strobe,
  output logic       rdValid
);

  always_comb begin
    strobe.wrGo      = wrEn;
    strobe.rdGo      = rdEn & ~rst;
    strobe.rdColMode = rdSelCol;
    strobe.clrOut    = rst;
  end

  always_ff @(posedge clk) begin
    if (rst) rdValid <= 1'b0;
    else     rdValid <= rdEn;
  end

endmodule

// File: rtl/matmem_datapath.sv
// Datapath: two banked copies of the matrix and the output register.
module matmem_datapath
  import matmem_pkg::*;
#(
  parameter int DIM  = 16,
  parameter int WORD = 32,
  localparam int IDXW = $clog2(DIM),
  localparam int BUSW = DIM * WORD
) (
  input  logic            clk,
  input  mm_strobe_t      strobe,
  input  logic [IDXW-1:0] wrRow,
  input  logic [IDXW-1:0] wrCol,
  input  logic [WORD-1:0] wrData,
  input  logic [IDXW-1:0] rdIdx,
  output logic [BUSW-1:0] rdData
);

  logic [BUSW-1:0] rowVec;  // row rdIdx, gathered from the column-banked copy
  logic [BUSW-1:0] colVec;  // column rdIdx, gathered from the row-banked copy

  for (genvar g = 0; g < DIM; g++) begin : g_bank
    logic rowBankWe;
    logic colBankWe;

    // Row-access copy: bank g holds column g, addressed by row index
    assign rowBankWe = strobe.wrGo && (wrCol == IDXW'(g));
    matmem_bank #(.DEPTH(DIM), .WIDTH(WORD)) u_rowBank (
      .clk   (clk),
      .we    (rowBankWe),
      .wAddr (wrRow),
      .wData (wrData),
      .rAddr (rdIdx),
      .rData (rowVec[g*WORD +: WORD])
    );

    // Column-access copy: bank g holds row g, addressed by column index
    assign colBankWe = strobe.wrGo && (wrRow == IDXW'(g));
    matmem_bank #(.DEPTH(DIM), .WIDTH(WORD)) u_colBank (
      .clk   (clk),
      .we    (colBankWe),
      .wAddr (wrCol),
      .wData (wrData),
      .rAddr (rdIdx),
      .rData (colVec[g*WORD +: WORD])
    );
  end

  always_ff @(posedge clk) begin
    if (strobe.clrOut)    rdData <= '0;
    else if (strobe.rdGo) rdData <= strobe.rdColMode ? colVec : rowVec;
  end

endmodule

// File: rtl/matmem_rowcol.sv
// Top: matrix store with one-element writes and whole row/column reads.
module matmem_rowcol
  import matmem_pkg::*;
#(
  parameter int DIM  = 16,
  parameter int WORD = 32,
  localparam int IDXW = $clog2(DIM),
  localparam int BUSW = DIM * WORD
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrRow,
  input  logic [IDXW-1:0] wrCol,
  input  logic [WORD-1:0] wrData,
  input  logic            rdEn,
  input  logic            rdSelCol,
  input  logic [IDXW-1:0] rdIdx,
  output logic [BUSW-1:0] rdData,
  output logic            rdValid
);

  mm_strobe_t strobe;

  matmem_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .rdSelCol (rdSelCol),
    .strobe   (strobe),
    .rdValid  (rdValid)
  );

  matmem_datapath #(.DIM(DIM), .WORD(WORD)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .wrRow  (wrRow),
    .wrCol  (wrCol),
    .wrData (wrData),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );

endmodule

// File: rtl/matmem_rowcol_chk.sv
// Checker bound to the top module.
module matmem_rowcol_chk #(
  parameter int DIM  = 16,
  parameter int WORD = 32,
  localparam int IDXW = $clog2(DIM),
  localparam int BUSW = DIM * WORD
) (
  input logic            clk,
  input logic            rst,
  input logic            wrEn,
  input logic [IDXW-1:0] wrRow,
  input logic [IDXW-1:0] wrCol,
  input logic [WORD-1:0] wrData,
  input logic            rdEn,
  input logic            rdSelCol,
  input logic [IDXW-1:0] rdIdx,
  input logic [BUSW-1:0] rdData,
  input logic            rdValid
);

  // R4: valid follows a request by one cycle
  a_r4_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    rdEn |=> rdValid);

  // R4: no request, no valid
  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> !rdValid);

  // R6: reset clears the output register and the flag
  a_r6_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (rdValid == 1'b0 && rdData == '0));

  // R7: output held while idle
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));

  // R1, R2: a write followed by a row read of that row shows the value
  a_r2_row_after_write: assert property (@(posedge clk) disable iff (rst)
    ($past(wrEn, 2) && $past(rdEn) && !$past(rdSelCol) && !$past(wrEn)
     && !$past(rst) && $past(rdIdx) == $past(wrRow, 2))
    |-> rdData[$past(wrCol, 2)*WORD +: WORD] == $past(wrData, 2));

  // R1, R3: a write followed by a column read of that column shows the value
  a_r3_col_after_write: assert property (@(posedge clk) disable iff (rst)
    ($past(wrEn, 2) && $past(rdEn) && $past(rdSelCol) && !$past(wrEn)
     && !$past(rst) && $past(rdIdx) == $past(wrCol, 2))
    |-> rdData[$past(wrRow, 2)*WORD +: WORD] == $past(wrData, 2));

endmodule

bind matmem_rowcol matmem_rowcol_chk #(.DIM(DIM), .WORD(WORD)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wrEn     (wrEn),
  .wrRow    (wrRow),
  .wrCol    (wrCol),
  .wrData   (wrData),
  .rdEn     (rdEn),
  .rdSelCol (rdSelCol),
  .rdIdx    (rdIdx),
  .rdData   (rdData),
  .rdValid  (rdValid)
);

// File: tb/matmem_rowcol_test.sv
`timescale 1ns/1ps
module matmem_rowcol_test;

  localparam int DIM  = 16;
  localparam int WORD = 32;
  localparam int BUSW = DIM * WORD;

  logic            clk = 1'b0;
  logic            rst;
  logic            wrEn;
  logic [3:0]      wrRow;
  logic [3:0]      wrCol;
  logic [WORD-1:0] wrData;
  logic            rdEn;
  logic            rdSelCol;
  logic [3:0]      rdIdx;
  logic [BUSW-1:0] rdData;
  logic            rdValid;

  int checks = 0;
  int fails  = 0;
  logic [WORD-1:0] model [DIM][DIM];

  always #2 clk = ~clk;  // 250 MHz

  matmem_rowcol #(.DIM(DIM), .WORD(WORD)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrRow(wrRow), .wrCol(wrCol),
    .wrData(wrData), .rdEn(rdEn), .rdSelCol(rdSelCol), .rdIdx(rdIdx),
    .rdData(rdData), .rdValid(rdValid)
  );

  // Read table: {select column, index}
  localparam logic [4:0] RD_TABLE [10] = '{
    5'b0_0000, 5'b0_0111, 5'b0_1111, 5'b1_0000, 5'b1_1111,
    5'b1_0101, 5'b0_1010, 5'b1_1010, 5'b0_0011, 5'b1_1100
  };

  function automatic logic [WORD-1:0] pat(int r, int c);
    return {4'(r), 4'(c), 24'h5A3C00 ^ 24'(r * 37 + c * 11)};
  endfunction

  function automatic logic [BUSW-1:0] expVec(logic sel, int idx);
    logic [BUSW-1:0] v;
    for (int k = 0; k < DIM; k++)
      v[k*WORD +: WORD] = sel ? model[k][idx] : model[idx][k];
    return v;
  endfunction

  task automatic checkVec(string tag, logic [BUSW-1:0] act, logic [BUSW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic doWrite(int r, int c, logic [WORD-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrRow = 4'(r); wrCol = 4'(c); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    model[r][c] = d;
  endtask

  // Issues one read; returns on the falling edge where the result is due
  task automatic doRead(logic sel, int idx);
    @(negedge clk);
    rdEn = 1'b1; rdSelCol = sel; rdIdx = 4'(idx);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [BUSW-1:0] held;
    rst = 1'b1; wrEn = 1'b0; wrRow = '0; wrCol = '0; wrData = '0;
    rdEn = 1'b0; rdSelCol = 1'b0; rdIdx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: reset state
    checkVec("R6 reset rdData", rdData, '0);
    checkBit("R6 reset rdValid", rdValid, 1'b0);

    // R1: fill every element
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        doWrite(r, c, pat(r, c));

    // R2, R3, R4: table of reads
    for (int i = 0; i < 10; i++) begin
      doRead(RD_TABLE[i][4], int'(RD_TABLE[i][3:0]));
      checkVec(RD_TABLE[i][4] ? "R3 column read" : "R2 row read",
               rdData, expVec(RD_TABLE[i][4], int'(RD_TABLE[i][3:0])));
      checkBit("R4 rdValid after request", rdValid, 1'b1);
    end

    // R4, R7: idle cycles drop valid and hold data
    held = rdData;
    repeat (3) @(negedge clk);
    checkBit("R4 rdValid low when idle", rdValid, 1'b0);
    checkVec("R7 rdData held", rdData, held);

    // R5: same-cycle write and read of element (3,5)
    @(negedge clk);
    wrEn = 1'b1; wrRow = 4'd3; wrCol = 4'd5; wrData = 32'hDEADBEEF;
    rdEn = 1'b1; rdSelCol = 1'b0; rdIdx = 4'd3;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    checkVec("R5 read-before-write old row", rdData, expVec(1'b0, 3));
    model[3][5] = 32'hDEADBEEF;
    doRead(1'b0, 3);
    checkVec("R5 new value on next row read", rdData, expVec(1'b0, 3));
    doRead(1'b1, 5);
    checkVec("R1 new value in column copy", rdData, expVec(1'b1, 5));

    // R8: overwrite corner elements
    doWrite(15, 0, 32'h11111111);
    doWrite(15, 0, 32'h22222222);
    doWrite(0, 15, 32'h33333333);
    doWrite(0, 15, 32'h44444444);
    doRead(1'b0, 15);
    checkVec("R8 last write wins row 15", rdData, expVec(1'b0, 15));
    doRead(1'b1, 0);
    checkVec("R8 last write wins column 0", rdData, expVec(1'b1, 0));
    doRead(1'b1, 15);
    checkVec("R8 last write wins column 15", rdData, expVec(1'b1, 15));

    // R6: reset mid-run clears output but keeps contents
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkVec("R6 reset clears rdData", rdData, '0);
    checkBit("R6 reset clears rdValid", rdValid, 1'b0);
    doRead(1'b0, 7);
    checkVec("R6 contents kept over reset", rdData, expVec(1'b0, 7));

    // R4: back-to-back reads, each result one cycle later
    @(negedge clk);
    rdEn = 1'b1; rdSelCol = 1'b1; rdIdx = 4'd2;
    @(negedge clk);
    checkVec("R3 back-to-back first", rdData, expVec(1'b1, 2));
    rdSelCol = 1'b0; rdIdx = 4'd9;
    @(negedge clk);
    rdEn = 1'b0;
    checkVec("R2 back-to-back second", rdData, expVec(1'b0, 9));
    checkBit("R4 valid stays high back-to-back", rdValid, 1'b1);
    @(negedge clk);
    checkBit("R4 valid drops after last request", rdValid, 1'b0);

    finishRun();
  end

endmodule